// File: doc/BRIEF.md
# Prescaled Timer Counter with Coherent Byte Readout

This block is a free-running 16-bit up-counter that an 8-bit bus reads one byte at a time. The counter advances once per count enable. A 3-bit select field picks the enable: one of seven power-of-two divisions of the bus clock, or the rising edges of an external clock pin. The pin is first brought into the bus clock domain by a two-stage synchronizer and then passed through an edge detector.

Software reads the count as two bytes at two addresses. Reading the high byte parks a copy of the low byte in a holding register. A later low-byte read returns that copy, so the two bytes always belong to the same count. The copy stays parked until the low byte is read, however much time passes in between. A self-clearing bit in the control byte zeroes the counter and the prescaler divider.

Address map (2-bit address): 0 is the control byte, 1 is the count high byte, 2 is the count low byte, and 3 is spare. The read data is combinational from the current address. Read side effects (capturing and releasing the held byte) take place on the clock edge at which `bus_re` is high.

Top module: `ptc_top`

## Requirements
- R1: After reset, the counter is 0, the select field is 0 and no low byte is held. A high-byte read and then a low-byte read issued in the first cycles after reset return 0x00 and 0x00.
- R2: With select code k in the range 0 to 6, the counter holds floor(m / 2^k) m clock edges after the control write that also pulsed the software clear. The counter never moves by more than +1 in a cycle, except when it is cleared.
- R3: With select code 7, each rising edge of the external pin adds exactly one to the counter, within three clock edges of the pin change. The bus clock divider then has no effect.
- R4: Address 0 reads as the select field in bits [2:0] with bits [7:3] zero. Address 3 reads as 0x00. A control write loads the select field from write-data bits [2:0].
- R5: The address-1 read returns count bits [15:8]. On that read edge, if nothing is held, count bits [7:0] are copied into the holding register.
- R6: While a byte is held, further high-byte reads leave it unchanged. A low-byte read returns the held byte and releases the hold, even after an arbitrarily long gap.
- R7: A low-byte read while nothing is held returns the live count bits [7:0].
- R8: Writing control data with bit 7 set clears the counter and the prescaler divider on that write edge. Bit 7 always reads back as 0.
- R9: The counter wraps from 0xFFFF to 0x0000 and keeps counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 control, 1 count high, 2 count low, 3 spare |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe; read side effects occur on the edge where it is high |
| bus_wdata | input | 8 | Write data; bit 7 is the software clear, bits [2:0] the select |
| bus_rdata | output | 8 | Read data for the current address |
| ext_clk_pin | input | 1 | External count clock, asynchronous to clk |

## Verification
The assertions assume that `bus_we` and `bus_re` are never high in the same cycle, and that each strobe names exactly one address. The capture and release properties rely on this, because a high-byte read and a low-byte read cannot coincide. They also assume that the external pin stays at each level for at least two bus clock cycles, so that every rising edge survives the synchronizer. The stimulus issues a single strobe per task call, holds each pin level for three cycles, and starts every measured interval with a clearing control write, so that the expected counts follow from edge counting alone.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_CNT_HI = 2'd1,
        REG_CNT_LO = 2'd2,
        REG_SPARE  = 2'd3
    } ptc_reg_e;

endpackage

// File: rtl/ptc_ext_sync.sv
module ptc_ext_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sh;
        logic                   last;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.sh   = {sync_q.sh[SYNC_STAGES-2:0], pin};
        sync_d.last = sync_q.sh[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rise = sync_q.sh[SYNC_STAGES-1] & ~sync_q.last;

endmodule

// File: rtl/ptc_prescaler.sv
module ptc_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    input  logic             ext_rise,
    output logic             tick
);

    localparam int N_SRC    = 1 << SEL_W;
    localparam int EXT_CODE = N_SRC - 1;
    localparam int DIV_W    = EXT_CODE - 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } pre_t;

    pre_t pre_d, pre_q;
    logic [N_SRC-1:0] tap;

    for (genvar k = 0; k < EXT_CODE; k++) begin : g_tap
        if (k == 0) begin : g_full
            assign tap[k] = 1'b1;
        end else begin : g_div
            assign tap[k] = &pre_q.div[k-1:0];
        end
    end
    assign tap[EXT_CODE] = ext_rise;

    always_comb begin
        pre_d = pre_q;
        if (clr) pre_d.div = '0;
        else     pre_d.div = pre_q.div + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign tick = tap[sel];

endmodule

// File: rtl/ptc_count_core.sv
module ptc_count_core #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                tick,
    input  logic                hi_rd,
    input  logic                lo_rd,
    output logic [2*BYTE_W-1:0] count,
    output logic                held,
    output logic [BYTE_W-1:0]   held_byte
);

    localparam int CNT_W = 2 * BYTE_W;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              hv;
        logic [BYTE_W-1:0] hb;
    } core_t;

    core_t core_d, core_q;

    always_comb begin
        core_d = core_q;
        if (clr)       core_d.cnt = '0;
        else if (tick) core_d.cnt = core_q.cnt + 1'b1;

        if (lo_rd) begin
            core_d.hv = 1'b0;
        end else if (hi_rd && !core_q.hv) begin
            core_d.hv = 1'b1;
            core_d.hb = core_q.cnt[BYTE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign count     = core_q.cnt;
    assign held      = core_q.hv;
    assign held_byte = core_q.hb;

endmodule

// File: rtl/ptc_top.sv
module ptc_top
    import ptc_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SEL_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              ext_clk_pin
);

    localparam int CNT_W   = 2 * BYTE_W;
    localparam int CLR_BIT = BYTE_W - 1;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              ctl_wr;
    logic              sw_clr;
    logic              hi_rd;
    logic              lo_rd;
    logic              ext_rise;
    logic              tick;
    logic [CNT_W-1:0]  cnt_val;
    logic              hold_vld;
    logic [BYTE_W-1:0] hold_val;
    logic              unused_wbits;

    assign ctl_wr       = bus_we && (bus_addr == REG_CTRL);
    assign sw_clr       = ctl_wr && bus_wdata[CLR_BIT];
    assign hi_rd        = bus_re && (bus_addr == REG_CNT_HI);
    assign lo_rd        = bus_re && (bus_addr == REG_CNT_LO);
    assign unused_wbits = ^bus_wdata[CLR_BIT-1:SEL_W];

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_wr) ctl_d.sel = bus_wdata[SEL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    ptc_ext_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ext_clk_pin),
        .rise (ext_rise)
    );

    ptc_prescaler #(.SEL_W(SEL_W)) pre_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sw_clr),
        .sel     (ctl_q.sel),
        .ext_rise(ext_rise),
        .tick    (tick)
    );

    ptc_count_core #(.BYTE_W(BYTE_W)) core_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sw_clr),
        .tick     (tick),
        .hi_rd    (hi_rd),
        .lo_rd    (lo_rd),
        .count    (cnt_val),
        .held     (hold_vld),
        .held_byte(hold_val)
    );

    always_comb begin
        unique case (bus_addr)
            REG_CTRL:   bus_rdata = BYTE_W'(ctl_q.sel);
            REG_CNT_HI: bus_rdata = cnt_val[CNT_W-1:BYTE_W];
            REG_CNT_LO: bus_rdata = hold_vld ? hold_val : cnt_val[BYTE_W-1:0];
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ptc_checker.sv
module ptc_checker
    import ptc_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          bus_addr,
    input logic                bus_we,
    input logic                bus_re,
    input logic [BYTE_W-1:0]   bus_wdata,
    input logic [BYTE_W-1:0]   bus_rdata,
    input logic [2*BYTE_W-1:0] cnt,
    input logic                hold_vld,
    input logic [BYTE_W-1:0]   hold_val,
    input logic [SEL_W-1:0]    sel
);

    localparam int CNT_W = 2 * BYTE_W;

    logic clr_wr;
    logic hi_rd;
    logic lo_rd;
    assign clr_wr = bus_we && (bus_addr == REG_CTRL) && bus_wdata[BYTE_W-1];
    assign hi_rd  = bus_re && (bus_addr == REG_CNT_HI);
    assign lo_rd  = bus_re && (bus_addr == REG_CNT_LO);

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> (CNT_W'(cnt - $past(cnt)) <= CNT_W'(1)));

    // R5
    hi_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_rd && !hold_vld) |=> (hold_vld && hold_val == $past(cnt[BYTE_W-1:0])));

    // R6
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_vld && !lo_rd) |=> (hold_vld && $stable(hold_val)));

    // R6
    lo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_rd |=> !hold_vld);

    // R8
    sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (cnt == '0));

    // R4
    ctrl_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_CTRL) |-> (bus_rdata == BYTE_W'(sel)));

    // R7
    lo_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_CNT_LO && !hold_vld) |-> (bus_rdata == cnt[BYTE_W-1:0]));

endmodule

bind ptc_top ptc_checker #(.BYTE_W(BYTE_W), .SEL_W(SEL_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_re   (bus_re),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .cnt      (cnt_val),
    .hold_vld (hold_vld),
    .hold_val (hold_val),
    .sel      (ctl_q.sel)
);

// File: tb/ptc_top_tb.sv
`timescale 1ns/100ps
module ptc_top_tb_top;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_HI   = 2'd1;
    localparam logic [1:0] A_LO   = 2'd2;
    localparam logic [1:0] A_SPR  = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ext_clk_pin = 1'b0;

    always #2.5 clk = ~clk;

    ptc_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_re     (bus_re),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .ext_clk_pin(ext_clk_pin)
    );

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t exp_q[$];
    event  smp_ev;
    int    n_cmp = 0;
    int    n_bad = 0;
    int    tb_edges = 0;

    always @(posedge clk) tb_edges <= tb_edges + 1;

    // monitor: pops one expected item per sampled read
    initial begin
        forever begin
            item_t it;
            @(smp_ev);
            it = exp_q.pop_front();
            n_cmp++;
            if (bus_rdata !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %02h expected %02h", it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        bus_re   = 1'b1;
        bus_addr = a;
        exp_q.push_back('{exp: e, tag: tag});
        #1;
        -> smp_ev;
        @(negedge clk);
        bus_re   = 1'b0;
        bus_addr = A_CTRL;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_addr  = A_CTRL;
        bus_wdata = 8'd0;
    endtask

    // control write with clear bit set; restarts the bench's edge count
    task automatic restart(input int k);
        wr(A_CTRL, 8'h80 | 8'(k));
        tb_edges = 0;
    endtask

    task automatic rd_pair(input int k, input string tag);
        int c;
        c = tb_edges >> k;
        rd(A_HI, 8'(c >> 8), tag);
        rd(A_LO, 8'(c), tag);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int held;
        int c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tb_edges = 0;

        // R1: cleared count, cleared hold; held low byte is the pre-increment 0
        rd(A_HI, 8'h00, "R1 high after reset");
        rd(A_LO, 8'h00, "R1 low held after reset");
        rd(A_CTRL, 8'h00, "R1 select after reset");
        rd(A_SPR, 8'h00, "R4 spare reads zero");

        // R2 / R5: each division, coherent pair
        for (int k = 0; k < 7; k++) begin
            restart(k);
            repeat (900 + 37 * k) @(negedge clk);
            rd_pair(k, $sformatf("R2 R5 divide code %0d", k));
        end

        // R6 / R7: hold survives gaps and repeated high reads
        restart(0);
        repeat (300) @(negedge clk);
        c = tb_edges;
        held = c & 8'hFF;
        rd(A_HI, 8'(c >> 8), "R5 high read");
        repeat (50) @(negedge clk);
        rd(A_HI, 8'(tb_edges >> 8), "R6 repeated high read");
        repeat (20) @(negedge clk);
        rd(A_LO, 8'(held), "R6 low returns held byte");
        rd(A_LO, 8'(tb_edges), "R7 low live after release");

        // R8: clear bit reads back zero, select retained
        restart(2);
        rd(A_CTRL, 8'h02, "R8 clear bit reads zero");
        rd(A_LO, 8'(tb_edges >> 2), "R8 counter cleared");
        wr(A_CTRL, 8'h05);
        rd(A_CTRL, 8'h05, "R4 select write");

        // R9: wrap past 0xFFFF
        restart(0);
        repeat (65539) @(negedge clk);
        rd_pair(0, "R9 wrap");

        // R3: external clock pin
        restart(7);
        rd_pair(0, "R3 cleared before pulses");
        for (int p = 0; p < 9; p++) begin
            ext_clk_pin = 1'b1;
            repeat (3) @(negedge clk);
            ext_clk_pin = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        rd(A_HI, 8'h00, "R3 external high");
        rd(A_LO, 8'h09, "R3 external low held");
        repeat (100) @(negedge clk);
        rd(A_LO, 8'h09, "R3 idle bus clock adds nothing");

        if (exp_q.size() != 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule